// File: doc/BRIEF.md
# Trap Entry Unit

This unit takes a one-cycle trap request with a cause word and a trap value and works out everything that changes when the hart takes that trap. It returns the new program counter, the new privilege level, the cause, exception PC and trap value for the handling mode, the saved interrupt-enable and previous-privilege status bits, and the debug cause, debug PC and saved privilege when the trap enters debug mode. The surrounding core owns the architectural registers. It applies each value when the matching write strobe is high.

One priority chain picks the outcome. A hart that is already in debug mode is only redirected. A breakpoint whose per-privilege capture bit is set enters debug mode. A trap from user or supervisor level goes to supervisor mode when its delegation bit is set. Every other trap goes to machine mode, and machine mode can vector interrupts. The cause word carries the interrupt flag in its top bit and the cause code in the bits below it. Privilege is encoded as user = 0, supervisor = 1, machine = 3.

Every result and strobe is registered. The results appear together in the cycle after the request, and the strobes are high for that one cycle only.

Top module: `trap_entry_unit`

## Requirements
- R1: While `rstN` is low, every write strobe is 0 and trap requests are ignored. After reset is released, no strobe rises until a request arrives.
- R2: If `inDebug` is high, a breakpoint (cause code 3, interrupt flag clear) sets the PC to `DBG_ENTRY`. Any other cause sets the PC to `DBG_EXC`. Only `pcWe` is raised.
- R3: A breakpoint taken at a privilege whose capture bit is set (`ebreakEnU`, `ebreakEnS` or `ebreakEnM`) enters debug mode. The unit raises `dbgWe`, sets debug cause 1, saves the PC and the privilege, switches to machine mode and sets the PC to `DBG_ENTRY`.
- R4: A trap goes to supervisor mode only when the current privilege is user or supervisor, the cause code is below XLEN, and the bit at the cause code is set in `mideleg` (interrupts) or `medeleg` (exceptions). Otherwise it goes to machine mode.
- R5: Supervisor entry sets the PC to `stvec` and the privilege to 1. It writes the cause word, PC and trap value to the supervisor cause, epc and tval values, copies `sie` into the saved-enable bit, stores bit 0 of the old privilege in the previous-privilege bit and clears the enable.
- R6: Machine entry sets the PC to `mtvec` with bit 0 cleared. If `mtvec` bit 0 is set and the trap is an interrupt, the target is raised by four times the cause code.
- R7: Machine entry sets the privilege to 3. It writes the machine cause, epc and tval values, copies `mie` into the saved-enable bit, stores the old privilege in the 2-bit previous-privilege field and clears the enable.
- R8: Every request produces exactly one cycle of `pcWe`, one cycle later. At most one of `sTrapWe`, `mTrapWe` and `dbgWe` is high at a time. No strobe is raised without a request, and back-to-back requests each produce their own results.
- R9: A breakpoint whose capture bit for the current privilege is clear is handled as an ordinary exception, through delegation or machine entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trapValid | input | 1 | One-cycle trap request |
| trapCause | input | XLEN | Cause word: top bit is the interrupt flag, the rest is the code |
| trapTval | input | XLEN | Trap value |
| curPc | input | XLEN | PC of the trapping instruction |
| curPriv | input | 2 | Current privilege |
| inDebug | input | 1 | Hart is in debug mode |
| ebreakEnM | input | 1 | Breakpoint capture in machine mode |
| ebreakEnS | input | 1 | Breakpoint capture in supervisor mode |
| ebreakEnU | input | 1 | Breakpoint capture in user mode |
| sie | input | 1 | Supervisor interrupt enable |
| mie | input | 1 | Machine interrupt enable |
| medeleg | input | XLEN | Exception delegation mask |
| mideleg | input | XLEN | Interrupt delegation mask |
| stvec | input | XLEN | Supervisor trap vector |
| mtvec | input | XLEN | Machine trap vector, bit 0 selects vectored mode |
| pcWe | output | 1 | PC write strobe |
| pcNext | output | XLEN | New PC |
| privWe | output | 1 | Privilege write strobe |
| privNext | output | 2 | New privilege |
| sTrapWe | output | 1 | Supervisor trap-state write strobe |
| scauseNext | output | XLEN | Supervisor cause |
| sepcNext | output | XLEN | Supervisor exception PC |
| stvalNext | output | XLEN | Supervisor trap value |
| spieNext | output | 1 | Supervisor saved enable |
| sppNext | output | 1 | Supervisor previous privilege |
| sieNext | output | 1 | Supervisor enable after entry |
| mTrapWe | output | 1 | Machine trap-state write strobe |
| mcauseNext | output | XLEN | Machine cause |
| mepcNext | output | XLEN | Machine exception PC |
| mtvalNext | output | XLEN | Machine trap value |
| mpieNext | output | 1 | Machine saved enable |
| mppNext | output | 2 | Machine previous privilege |
| mieNext | output | 1 | Machine enable after entry |
| dbgWe | output | 1 | Debug-entry write strobe |
| dbgCauseNext | output | 3 | Debug cause |
| dpcNext | output | XLEN | Debug PC |
| dbgPrivNext | output | 2 | Privilege saved on debug entry |

## Verification
Properties check on every cycle that the three destination strobes are mutually exclusive, that a request is followed by exactly one PC strobe, and that a redirect inside debug mode touches nothing but the PC. They also check that machine level never reaches supervisor entry, and that each entry path lands on its privilege, vector and saved PC. Only the bench scenarios show the values that depend on the whole priority chain. These are the delegation mask chosen for interrupts versus exceptions, cause codes at or above XLEN, the vectored offset, breakpoints with capture on and off at each level, and the saved enable and privilege fields.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [2:0] {
    PATH_DBG_BRK,
    PATH_DBG_EXC,
    PATH_DBG_ENTER,
    PATH_SUP,
    PATH_MACH
  } trapPath_e;

  typedef struct packed {
    logic pcWe;
    logic privWe;
    logic sTrapWe;
    logic mTrapWe;
    logic dbgWe;
  } trapStrobe_t;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;
  localparam int         BRKPT_CODE = 3;
  localparam logic [2:0] DBG_CAUSE_SWBRK = 3'd1;
endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            trapValid,
  input  logic [XLEN-1:0] trapCause,
  input  logic [1:0]      curPriv,
  input  logic            inDebug,
  input  logic            ebreakEnM,
  input  logic            ebreakEnS,
  input  logic            ebreakEnU,
  input  logic [XLEN-1:0] medeleg,
  input  logic [XLEN-1:0] mideleg,
  output trapStrobe_t     strobe,
  output trapPath_e       path
);
  localparam int CW = $clog2(XLEN);
  localparam logic [XLEN-2:0] CODE_LIMIT = (XLEN-1)'(XLEN);
  localparam logic [XLEN-2:0] BRK_CODE   = (XLEN-1)'(BRKPT_CODE);

  logic            isIntr;
  logic [XLEN-2:0] code;
  logic            isBrk;
  logic            brkCapture;
  logic [XLEN-1:0] delegMask;
  logic            delegHit;
  logic            lowPriv;

  assign isIntr    = trapCause[XLEN-1];
  assign code      = trapCause[XLEN-2:0];
  assign isBrk     = !isIntr && (code == BRK_CODE);
  assign delegMask = isIntr ? mideleg : medeleg;
  assign delegHit  = (code < CODE_LIMIT) && delegMask[code[CW-1:0]];
  assign lowPriv   = (curPriv == PRIV_U) || (curPriv == PRIV_S);

  always_comb begin
    case (curPriv)
      PRIV_U:  brkCapture = ebreakEnU;
      PRIV_S:  brkCapture = ebreakEnS;
      PRIV_M:  brkCapture = ebreakEnM;
      default: brkCapture = 1'b0;
    endcase
  end

  // priority chain: debug redirect, debug entry, delegation, machine
  always_comb begin
    if (inDebug)                path = isBrk ? PATH_DBG_BRK : PATH_DBG_EXC;
    else if (isBrk && brkCapture) path = PATH_DBG_ENTER;
    else if (lowPriv && delegHit) path = PATH_SUP;
    else                        path = PATH_MACH;
  end

  always_comb begin
    strobe.pcWe    = trapValid;
    strobe.privWe  = trapValid && (path inside {PATH_DBG_ENTER, PATH_SUP, PATH_MACH});
    strobe.sTrapWe = trapValid && (path == PATH_SUP);
    strobe.mTrapWe = trapValid && (path == PATH_MACH);
    strobe.dbgWe   = trapValid && (path == PATH_DBG_ENTER);
  end
endmodule

// File: rtl/trap_datapath.sv
module trap_datapath
  import trap_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] DBG_ENTRY = 'h800,
  parameter logic [XLEN-1:0] DBG_EXC   = 'h808
) (
  input  logic            clk,
  input  logic            rstN,
  input  trapStrobe_t     strobe,
  input  trapPath_e       path,
  input  logic [XLEN-1:0] trapCause,
  input  logic [XLEN-1:0] trapTval,
  input  logic [XLEN-1:0] curPc,
  input  logic [1:0]      curPriv,
  input  logic            sie,
  input  logic            mie,
  input  logic [XLEN-1:0] stvec,
  input  logic [XLEN-1:0] mtvec,
  output trapStrobe_t     strobeQ,
  output logic [XLEN-1:0] pcNext,
  output logic [1:0]      privNext,
  output logic [XLEN-1:0] causeQ,
  output logic [XLEN-1:0] epcQ,
  output logic [XLEN-1:0] tvalQ,
  output logic            spieNext,
  output logic            sppNext,
  output logic            mpieNext,
  output logic [1:0]      mppNext,
  output logic [1:0]      dbgPrivNext
);
  logic [XLEN-1:0] machBase;
  logic [XLEN-1:0] vecOffset;
  logic [XLEN-1:0] machTarget;
  logic [XLEN-1:0] pcTarget;
  logic [1:0]      privTarget;

  assign machBase   = {mtvec[XLEN-1:1], 1'b0};
  assign vecOffset  = (mtvec[0] && trapCause[XLEN-1]) ? {trapCause[XLEN-3:0], 2'b00} : '0;
  assign machTarget = machBase + vecOffset;

  always_comb begin
    case (path)
      PATH_DBG_BRK, PATH_DBG_ENTER: pcTarget = DBG_ENTRY;
      PATH_DBG_EXC:                 pcTarget = DBG_EXC;
      PATH_SUP:                     pcTarget = stvec;
      default:                      pcTarget = machTarget;
    endcase
    case (path)
      PATH_SUP:                 privTarget = PRIV_S;
      PATH_DBG_ENTER, PATH_MACH: privTarget = PRIV_M;
      default:                  privTarget = curPriv;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobeQ     <= '0;
      pcNext      <= '0;
      privNext    <= PRIV_M;
      causeQ      <= '0;
      epcQ        <= '0;
      tvalQ       <= '0;
      spieNext    <= 1'b0;
      sppNext     <= 1'b0;
      mpieNext    <= 1'b0;
      mppNext     <= PRIV_U;
      dbgPrivNext <= PRIV_U;
    end else begin
      strobeQ <= strobe;
      if (strobe.pcWe) begin
        pcNext      <= pcTarget;
        privNext    <= privTarget;
        causeQ      <= trapCause;
        epcQ        <= curPc;
        tvalQ       <= trapTval;
        spieNext    <= sie;
        sppNext     <= curPriv[0];
        mpieNext    <= mie;
        mppNext     <= curPriv;
        dbgPrivNext <= curPriv;
      end
    end
  end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] DBG_ENTRY = 'h800,
  parameter logic [XLEN-1:0] DBG_EXC   = 'h808
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            trapValid,
  input  logic [XLEN-1:0] trapCause,
  input  logic [XLEN-1:0] trapTval,
  input  logic [XLEN-1:0] curPc,
  input  logic [1:0]      curPriv,
  input  logic            inDebug,
  input  logic            ebreakEnM,
  input  logic            ebreakEnS,
  input  logic            ebreakEnU,
  input  logic            sie,
  input  logic            mie,
  input  logic [XLEN-1:0] medeleg,
  input  logic [XLEN-1:0] mideleg,
  input  logic [XLEN-1:0] stvec,
  input  logic [XLEN-1:0] mtvec,
  output logic            pcWe,
  output logic [XLEN-1:0] pcNext,
  output logic            privWe,
  output logic [1:0]      privNext,
  output logic            sTrapWe,
  output logic [XLEN-1:0] scauseNext,
  output logic [XLEN-1:0] sepcNext,
  output logic [XLEN-1:0] stvalNext,
  output logic            spieNext,
  output logic            sppNext,
  output logic            sieNext,
  output logic            mTrapWe,
  output logic [XLEN-1:0] mcauseNext,
  output logic [XLEN-1:0] mepcNext,
  output logic [XLEN-1:0] mtvalNext,
  output logic            mpieNext,
  output logic [1:0]      mppNext,
  output logic            mieNext,
  output logic            dbgWe,
  output logic [2:0]      dbgCauseNext,
  output logic [XLEN-1:0] dpcNext,
  output logic [1:0]      dbgPrivNext
);
  trapStrobe_t     strobe;
  trapStrobe_t     strobeQ;
  trapPath_e       path;
  logic [XLEN-1:0] causeQ;
  logic [XLEN-1:0] epcQ;
  logic [XLEN-1:0] tvalQ;

  trap_ctrl #(.XLEN(XLEN)) u_ctrl (
    .trapValid(trapValid), .trapCause(trapCause), .curPriv(curPriv),
    .inDebug(inDebug), .ebreakEnM(ebreakEnM), .ebreakEnS(ebreakEnS),
    .ebreakEnU(ebreakEnU), .medeleg(medeleg), .mideleg(mideleg),
    .strobe(strobe), .path(path)
  );

  trap_datapath #(.XLEN(XLEN), .DBG_ENTRY(DBG_ENTRY), .DBG_EXC(DBG_EXC)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .path(path),
    .trapCause(trapCause), .trapTval(trapTval), .curPc(curPc),
    .curPriv(curPriv), .sie(sie), .mie(mie), .stvec(stvec), .mtvec(mtvec),
    .strobeQ(strobeQ), .pcNext(pcNext), .privNext(privNext),
    .causeQ(causeQ), .epcQ(epcQ), .tvalQ(tvalQ),
    .spieNext(spieNext), .sppNext(sppNext), .mpieNext(mpieNext),
    .mppNext(mppNext), .dbgPrivNext(dbgPrivNext)
  );

  assign pcWe         = strobeQ.pcWe;
  assign privWe       = strobeQ.privWe;
  assign sTrapWe      = strobeQ.sTrapWe;
  assign mTrapWe      = strobeQ.mTrapWe;
  assign dbgWe        = strobeQ.dbgWe;
  assign scauseNext   = causeQ;
  assign sepcNext     = epcQ;
  assign stvalNext    = tvalQ;
  assign mcauseNext   = causeQ;
  assign mepcNext     = epcQ;
  assign mtvalNext    = tvalQ;
  assign dpcNext      = epcQ;
  assign sieNext      = 1'b0;
  assign mieNext      = 1'b0;
  assign dbgCauseNext = DBG_CAUSE_SWBRK;
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
  import trap_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] DBG_ENTRY = 'h800
) (
  input logic            clk,
  input logic            rstN,
  input logic            trapValid,
  input logic            inDebug,
  input logic [1:0]      curPriv,
  input logic [XLEN-1:0] curPc,
  input logic [XLEN-1:0] stvec,
  input logic            pcWe,
  input logic            privWe,
  input logic            sTrapWe,
  input logic            mTrapWe,
  input logic            dbgWe,
  input logic [1:0]      privNext,
  input logic [XLEN-1:0] pcNext,
  input logic [XLEN-1:0] mepcNext,
  input logic [XLEN-1:0] dpcNext
);
  p_one_target_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sTrapWe, mTrapWe, dbgWe}));

  p_req_gives_pc_r8: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> pcWe);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !trapValid |=> !pcWe && !privWe);

  p_dbg_redirect_r2: assert property (@(posedge clk) disable iff (!rstN)
    trapValid && inDebug |=> !privWe && !sTrapWe && !mTrapWe && !dbgWe);

  p_no_sup_from_m_r4: assert property (@(posedge clk) disable iff (!rstN)
    trapValid && !inDebug && curPriv == PRIV_M |=> !sTrapWe);

  p_sup_entry_r5: assert property (@(posedge clk) disable iff (!rstN)
    sTrapWe |-> privWe && privNext == PRIV_S && pcNext == $past(stvec));

  p_mach_entry_r7: assert property (@(posedge clk) disable iff (!rstN)
    mTrapWe |-> privWe && privNext == PRIV_M && mepcNext == $past(curPc));

  p_dbg_entry_r3: assert property (@(posedge clk) disable iff (!rstN)
    dbgWe |-> pcNext == DBG_ENTRY && privNext == PRIV_M && dpcNext == $past(curPc));
endmodule

bind trap_entry_unit trap_entry_chk #(.XLEN(XLEN), .DBG_ENTRY(DBG_ENTRY)) u_chk (
  .clk(clk), .rstN(rstN), .trapValid(trapValid), .inDebug(inDebug),
  .curPriv(curPriv), .curPc(curPc), .stvec(stvec), .pcWe(pcWe),
  .privWe(privWe), .sTrapWe(sTrapWe), .mTrapWe(mTrapWe), .dbgWe(dbgWe),
  .privNext(privNext), .pcNext(pcNext), .mepcNext(mepcNext), .dpcNext(dpcNext)
);

// File: tb/trap_entry_unit_tb.sv
module trap_entry_unit_tb;
  localparam logic [31:0] DBG_ENTRY = 32'h800;
  localparam logic [31:0] DBG_EXC   = 32'h808;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trapValid = 1'b0;
  logic [31:0] trapCause = '0, trapTval = '0, curPc = '0;
  logic [1:0]  curPriv = 2'd3;
  logic inDebug = 1'b0, ebreakEnM = 1'b0, ebreakEnS = 1'b0, ebreakEnU = 1'b0;
  logic sie = 1'b0, mie = 1'b0;
  logic [31:0] medeleg = '0, mideleg = '0;
  logic [31:0] stvec = 32'h2000_0100, mtvec = 32'h3000_0000;

  logic pcWe, privWe, sTrapWe, mTrapWe, dbgWe;
  logic [31:0] pcNext, scauseNext, sepcNext, stvalNext, mcauseNext, mepcNext, mtvalNext, dpcNext;
  logic [1:0]  privNext, mppNext, dbgPrivNext;
  logic spieNext, sppNext, sieNext, mpieNext, mieNext;
  logic [2:0]  dbgCauseNext;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  trap_entry_unit #(.XLEN(32), .DBG_ENTRY(DBG_ENTRY), .DBG_EXC(DBG_EXC)) u_dut (
    .clk(clk), .rstN(rstN), .trapValid(trapValid), .trapCause(trapCause),
    .trapTval(trapTval), .curPc(curPc), .curPriv(curPriv), .inDebug(inDebug),
    .ebreakEnM(ebreakEnM), .ebreakEnS(ebreakEnS), .ebreakEnU(ebreakEnU),
    .sie(sie), .mie(mie), .medeleg(medeleg), .mideleg(mideleg),
    .stvec(stvec), .mtvec(mtvec),
    .pcWe(pcWe), .pcNext(pcNext), .privWe(privWe), .privNext(privNext),
    .sTrapWe(sTrapWe), .scauseNext(scauseNext), .sepcNext(sepcNext),
    .stvalNext(stvalNext), .spieNext(spieNext), .sppNext(sppNext), .sieNext(sieNext),
    .mTrapWe(mTrapWe), .mcauseNext(mcauseNext), .mepcNext(mepcNext),
    .mtvalNext(mtvalNext), .mpieNext(mpieNext), .mppNext(mppNext), .mieNext(mieNext),
    .dbgWe(dbgWe), .dbgCauseNext(dbgCauseNext), .dpcNext(dpcNext), .dbgPrivNext(dbgPrivNext)
  );

  // kind: 0 debug redirect, 1 debug entry, 2 supervisor, 3 machine
  typedef struct {
    int          kind;
    logic [31:0] pc;
    logic [1:0]  priv;
    logic [31:0] cause;
    logic [31:0] epc;
    logic [31:0] tval;
    logic        pie;
    logic [1:0]  oldPriv;
    string       req;
  } exp_t;

  exp_t expQ[$];

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic exp_t model(string req);
    exp_t e;
    logic intr;
    logic [30:0] code;
    logic capture;
    logic [31:0] mask;
    intr = trapCause[31];
    code = trapCause[30:0];
    capture = (curPriv == 2'd0) ? ebreakEnU : (curPriv == 2'd1) ? ebreakEnS :
              (curPriv == 2'd3) ? ebreakEnM : 1'b0;
    mask = intr ? mideleg : medeleg;
    e.req = req; e.cause = trapCause; e.epc = curPc; e.tval = trapTval;
    e.oldPriv = curPriv; e.priv = curPriv; e.pie = 1'b0;
    if (inDebug) begin
      e.kind = 0;
      e.pc = (!intr && code == 31'd3) ? DBG_ENTRY : DBG_EXC;
    end else if (!intr && code == 31'd3 && capture) begin
      e.kind = 1; e.pc = DBG_ENTRY; e.priv = 2'd3;
    end else if (curPriv <= 2'd1 && code < 31'd32 && mask[code[4:0]]) begin
      e.kind = 2; e.pc = stvec; e.priv = 2'd1; e.pie = sie;
    end else begin
      e.kind = 3; e.priv = 2'd3; e.pie = mie;
      e.pc = {mtvec[31:1], 1'b0} + ((mtvec[0] && intr) ? {code[29:0], 2'b00} : 32'd0);
    end
    return e;
  endfunction

  // driver: called at a falling edge, returns at the next falling edge
  task automatic issue(string req, logic [31:0] cause, logic [31:0] tval,
                       logic [31:0] pc, logic [1:0] priv, logic dbg);
    trapCause = cause; trapTval = tval; curPc = pc; curPriv = priv; inDebug = dbg;
    expQ.push_back(model(req));
    trapValid = 1'b1;
    @(negedge clk);
    trapValid = 1'b0;
  endtask

  // monitor: results appear one edge after the request
  always @(negedge clk) begin
    if (rstN) begin
      if (pcWe) begin
        if (expQ.size() == 0) begin
          chk("R8", "unexpected pcWe", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          chk(e.req, "pcNext", pcNext, e.pc);
          chk(e.req, "privWe", {31'd0, privWe}, {31'd0, e.kind != 0});
          chk(e.req, "sTrapWe", {31'd0, sTrapWe}, {31'd0, e.kind == 2});
          chk(e.req, "mTrapWe", {31'd0, mTrapWe}, {31'd0, e.kind == 3});
          chk(e.req, "dbgWe", {31'd0, dbgWe}, {31'd0, e.kind == 1});
          if (e.kind != 0) chk(e.req, "privNext", {30'd0, privNext}, {30'd0, e.priv});
          if (e.kind == 1) begin
            chk(e.req, "dbgCause", {29'd0, dbgCauseNext}, 32'd1);
            chk(e.req, "dpc", dpcNext, e.epc);
            chk(e.req, "dbgPriv", {30'd0, dbgPrivNext}, {30'd0, e.oldPriv});
          end
          if (e.kind == 2) begin
            chk(e.req, "scause", scauseNext, e.cause);
            chk(e.req, "sepc", sepcNext, e.epc);
            chk(e.req, "stval", stvalNext, e.tval);
            chk(e.req, "spie", {31'd0, spieNext}, {31'd0, e.pie});
            chk(e.req, "spp", {31'd0, sppNext}, {31'd0, e.oldPriv[0]});
            chk(e.req, "sie", {31'd0, sieNext}, 32'd0);
          end
          if (e.kind == 3) begin
            chk(e.req, "mcause", mcauseNext, e.cause);
            chk(e.req, "mepc", mepcNext, e.epc);
            chk(e.req, "mtval", mtvalNext, e.tval);
            chk(e.req, "mpie", {31'd0, mpieNext}, {31'd0, e.pie});
            chk(e.req, "mpp", {30'd0, mppNext}, {30'd0, e.oldPriv});
            chk(e.req, "mie", {31'd0, mieNext}, 32'd0);
          end
        end
      end else if (privWe || sTrapWe || mTrapWe || dbgWe) begin
        chk("R8", "strobe without pcWe", 32'd1, 32'd0);
      end
    end
  end

  initial begin
    #2_000_000ns;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: requests during reset are ignored
    @(negedge clk);
    trapValid = 1'b1; trapCause = 32'd2;
    repeat (3) @(negedge clk);
    chk("R1", "strobes in reset", {27'd0, pcWe, privWe, sTrapWe, mTrapWe, dbgWe}, 32'd0);
    trapValid = 1'b0;
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "strobes after reset", {27'd0, pcWe, privWe, sTrapWe, mTrapWe, dbgWe}, 32'd0);

    // R2: already in debug mode
    issue("R2", 32'd3, 32'h11, 32'h400, 2'd1, 1'b1);
    issue("R2", 32'd2, 32'h12, 32'h404, 2'd0, 1'b1);

    // R3: breakpoint capture at M and U
    ebreakEnM = 1'b1; ebreakEnU = 1'b1;
    issue("R3", 32'd3, 32'h0, 32'h100, 2'd3, 1'b0);
    issue("R3", 32'd3, 32'h0, 32'h104, 2'd0, 1'b0);

    // R9: capture off at S, breakpoint handled normally
    ebreakEnS = 1'b0; medeleg = 32'h0;
    issue("R9", 32'd3, 32'h21, 32'h108, 2'd1, 1'b0);
    medeleg = 32'h8;
    issue("R9", 32'd3, 32'h22, 32'h10c, 2'd1, 1'b0);

    // R5: delegated exception from U
    sie = 1'b1; mie = 1'b1; medeleg = 32'h100;
    issue("R5", 32'd8, 32'h33, 32'h200, 2'd0, 1'b0);
    // R4: same exception from M is not delegated
    issue("R4", 32'd8, 32'h34, 32'h204, 2'd3, 1'b0);
    // R4: interrupt uses the interrupt mask
    mideleg = 32'h20; medeleg = 32'h0;
    issue("R4", 32'h8000_0005, 32'h0, 32'h208, 2'd1, 1'b0);
    // R6: interrupt not delegated even though exception mask bit 5 set; vectored
    mideleg = 32'h0; medeleg = 32'h20; mtvec = 32'h3000_0001;
    issue("R6", 32'h8000_0005, 32'h0, 32'h20c, 2'd1, 1'b0);
    // R6: exception in vectored mode gets no offset
    issue("R6", 32'd2, 32'h44, 32'h210, 2'd3, 1'b0);
    // R4: code at or above XLEN never delegates
    medeleg = 32'hffff_ffff; sie = 1'b0; mie = 1'b0;
    issue("R4", 32'd40, 32'h55, 32'h214, 2'd0, 1'b0);

    // R8: back-to-back requests
    mtvec = 32'h3000_0000;
    issue("R8", 32'd13, 32'h66, 32'h300, 2'd1, 1'b0);
    issue("R7", 32'h8000_0007, 32'h0, 32'h304, 2'd1, 1'b0);

    repeat (3) @(negedge clk);
    chk("R8", "idle pcWe", {31'd0, pcWe}, 32'd0);
    chk("R8", "pending results", expQ.size(), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule